// File: doc/BRIEF.md
# Half-Bridge Gate Command Generator with Deadtime

This block turns an internal square-wave timebase into two complementary gate commands, one for the low-side switch and one for the high-side switch of a half-bridge. Each half of the switching cycle starts with a deadtime interval in which both commands are low. The matching switch is then turned on for the rest of that half. This gives a 50% duty cycle with a non-overlapping gap before every turn-on. The half-period and the deadtime are counted in clock cycles. They come in as register values, which the frequency-control logic may rewrite at any time. The block takes them up only at cycle boundaries.

A mode sequencer drives `enable`. When it is low (lockout or fault), both commands are held low. When it rises, switching always begins with the low side. The high-side command stays suppressed until `boot_ok` reports that the floating bootstrap supply is charged, so the first few cycles may drive only the low side. A one-clock `lo_tick` pulse marks every falling edge of the low-side command. Fault counters downstream count switching cycles with it.

Top module: `hb_gate_driver`

## Requirements
- R1: While enabled, each half-cycle lasts exactly the effective half-period HP clocks: the first DT clocks have both commands low, then the half's command (low side first, then high side) is high for HP-DT clocks, giving a full period of 2*HP clocks.
- R2: After reset, and from the first clock edge at which `enable` is sampled low, both `gate_lo` and `gate_hi` are low.
- R3: `gate_lo` and `gate_hi` are never high in the same cycle, including across parameter changes.
- R4: `gate_hi` is low in every cycle following an edge at which `boot_ok` was low; `gate_lo` keeps switching meanwhile.
- R5: A requested half-period below 2 is used as 2, and a requested deadtime equal to or above the effective half-period is used as HP-1, so each on-time is at least one clock.
- R6: `half_period` and `dead_time` are sampled only when enable starts the sequence and at the start of each low-side half-cycle; a change made mid-cycle leaves the remaining low-side on-time, the following high-side half and its deadtime unchanged.
- R7: `lo_tick` is high for exactly one clock in the first cycle in which `gate_lo` reads low after being high, and at no other time.
- R8: On enable or re-enable the sequence restarts in the low-side half: with `enable` sampled high at edge E0, `gate_lo` first goes high after edge E0+DT+1 and `gate_hi` stays low before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request from the mode sequencer |
| half_period | input | CNT_W | Requested half-period in clocks |
| dead_time | input | CNT_W | Requested deadtime in clocks |
| boot_ok | input | 1 | High-side bootstrap supply is valid |
| gate_lo | output | 1 | Low-side gate command |
| gate_hi | output | 1 | High-side gate command |
| lo_tick | output | 1 | One-clock pulse per low-side falling edge |

## Verification
The properties check the invariants in every cycle. These are the mutual exclusion of the two commands, the forced-off state one edge after enable or the bootstrap flag drops, the tick coinciding with a low-side fall, the counter staying inside the latched half-period, and the latched values staying clamped and frozen between load points. The measured on-times and deadtimes, the clamping of out-of-range requests, the delay before a mid-cycle update takes effect and the restart in the low-side phase are all multi-cycle timing relations. Only the bench's directed scenarios show them, by counting cycles at the ports.

// File: rtl/hbg_pkg.sv
// Shared types for the half-bridge gate command generator.
// Assumes: nothing beyond a standard SystemVerilog flow.
package hbg_pkg;

    // Which switch owns the current half of the switching cycle.
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

endpackage

// File: rtl/hbg_param_latch.sv
// Clamps the requested half-period and deadtime and holds them between
// load strobes, so the timebase only sees new values at cycle boundaries.
// Assumes: load is a single-cycle strobe from the phase timer.
module hbg_param_latch #(
    parameter int CNT_W    = 16,
    parameter int DEF_HALF = 1000,
    parameter int DEF_DEAD = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] half_in,
    input  logic [CNT_W-1:0] dead_in,
    output logic [CNT_W-1:0] hp_r,
    output logic [CNT_W-1:0] dt_r
);

    localparam int RST_HP_I = (DEF_HALF < 2) ? 2 : DEF_HALF;
    localparam int RST_DT_I = (DEF_DEAD >= RST_HP_I) ? RST_HP_I - 1 : DEF_DEAD;
    localparam logic [CNT_W-1:0] RST_HP = CNT_W'(RST_HP_I);
    localparam logic [CNT_W-1:0] RST_DT = CNT_W'(RST_DT_I);
    localparam logic [CNT_W-1:0] MIN_HP = CNT_W'(2);

    logic [CNT_W-1:0] hp_clamp;
    logic [CNT_W-1:0] dt_clamp;

    // Force a usable half-period and a deadtime that leaves on-time.
    always_comb begin
        hp_clamp = (half_in < MIN_HP) ? MIN_HP : half_in;
        dt_clamp = (dead_in >= hp_clamp) ? (hp_clamp - 1'b1) : dead_in;
    end

    // Capture the clamped pair only on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_r <= RST_HP;
            dt_r <= RST_DT;
        end else if (load) begin
            hp_r <= hp_clamp;
            dt_r <= dt_clamp;
        end
    end

    p_dead_clamped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_r < hp_r) && (hp_r >= MIN_HP));

    p_hold_between_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(hp_r) && $stable(dt_r)));

endmodule

// File: rtl/hbg_phase_timer.sv
// Timebase: counts clocks within each half-cycle and alternates between
// the low-side and high-side halves. Always starts in the low-side half.
// Assumes: hp_r is at least 2 and is only changed when load is high.
module hbg_phase_timer
    import hbg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] hp_r,
    output logic             running,
    output half_e            half,
    output logic [CNT_W-1:0] cnt,
    output logic             load
);

    logic half_end;

    // Detect the last clock of the current half and the load points.
    always_comb begin
        half_end = (cnt == hp_r - 1'b1);
        load     = enable && (!running || (half_end && half == HALF_HI));
    end

    // Advance the count, flip halves, restart low side on enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            running <= 1'b0;
            half    <= HALF_LO;
            cnt     <= '0;
        end else if (!running) begin
            running <= 1'b1;
            half    <= HALF_LO;
            cnt     <= '0;
        end else if (half_end) begin
            cnt  <= '0;
            half <= (half == HALF_LO) ? HALF_HI : HALF_LO;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < hp_r));

    p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !running) |=> (half == HALF_LO && cnt == '0));

endmodule

// File: rtl/hbg_output_stage.sv
// Registers the two gate commands from the timebase state, applies the
// bootstrap qualification to the high side and marks low-side falls.
// Assumes: dt_r < hp_r, so each half has at least one on clock.
module hbg_output_stage
    import hbg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             boot_ok,
    input  logic             running,
    input  half_e            half,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] dt_r,
    output logic             gate_lo,
    output logic             gate_hi,
    output logic             lo_tick
);

    logic past_dead;
    logic lo_next;
    logic hi_next;

    // Decide what each command should be after this edge.
    always_comb begin
        past_dead = (cnt >= dt_r);
        lo_next   = enable && running && (half == HALF_LO) && past_dead;
        hi_next   = enable && running && boot_ok && (half == HALF_HI) && past_dead;
    end

    // Register the commands and the low-side fall marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_lo <= 1'b0;
            gate_hi <= 1'b0;
            lo_tick <= 1'b0;
        end else begin
            gate_lo <= lo_next;
            gate_hi <= hi_next;
            lo_tick <= gate_lo && !lo_next;
        end
    end

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_lo && gate_hi));

    p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate_lo && !gate_hi));

    p_hi_needs_boot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_ok |=> !gate_hi);

    p_tick_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_tick |-> (!gate_lo && $past(gate_lo)));

endmodule

// File: rtl/hb_gate_driver.sv
// Top level: complementary half-bridge gate commands with programmable
// half-period and deadtime, high-side bootstrap gating and a per-cycle
// low-side tick. Assumes synchronous inputs in the clk domain.
module hb_gate_driver
    import hbg_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DEF_HALF = 1000,
    parameter int DEF_DEAD = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] half_period,
    input  logic [CNT_W-1:0] dead_time,
    input  logic             boot_ok,
    output logic             gate_lo,
    output logic             gate_hi,
    output logic             lo_tick
);

    logic             running;
    half_e            half;
    logic [CNT_W-1:0] cnt;
    logic             load;
    logic [CNT_W-1:0] hp_r;
    logic [CNT_W-1:0] dt_r;

    hbg_param_latch #(
        .CNT_W    (CNT_W),
        .DEF_HALF (DEF_HALF),
        .DEF_DEAD (DEF_DEAD)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .half_in (half_period),
        .dead_in (dead_time),
        .hp_r    (hp_r),
        .dt_r    (dt_r)
    );

    hbg_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .hp_r    (hp_r),
        .running (running),
        .half    (half),
        .cnt     (cnt),
        .load    (load)
    );

    hbg_output_stage #(
        .CNT_W (CNT_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .boot_ok (boot_ok),
        .running (running),
        .half    (half),
        .cnt     (cnt),
        .dt_r    (dt_r),
        .gate_lo (gate_lo),
        .gate_hi (gate_hi),
        .lo_tick (lo_tick)
    );

endmodule

// File: tb/hb_gate_driver_test.sv
`timescale 1ns/1ps
module hb_gate_driver_test;

    localparam int CNT_W = 16;

    // half_period, dead_time, expected on-time, expected deadtime
    localparam int VEC [6][4] = '{
        '{10,  3,  7,  3},
        '{16,  1, 15,  1},
        '{ 6,  9,  1,  5},
        '{ 1,  4,  1,  1},
        '{20, 19,  1, 19},
        '{ 5,  0,  5,  0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [CNT_W-1:0] half_period = 16'd10;
    logic [CNT_W-1:0] dead_time = 16'd3;
    logic             boot_ok = 1'b0;
    logic             gate_lo;
    logic             gate_hi;
    logic             lo_tick;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int overlaps = 0;
    int tick_errs = 0;
    bit done = 1'b0;
    logic prev_lo = 1'b0;

    hb_gate_driver #(.CNT_W(CNT_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .half_period (half_period),
        .dead_time   (dead_time),
        .boot_ok     (boot_ok),
        .gate_lo     (gate_lo),
        .gate_hi     (gate_hi),
        .lo_tick     (lo_tick)
    );

    always #2.5 clk = ~clk;

    // Continuous monitors: overlap (R3) and tick alignment (R7).
    always @(negedge clk) begin
        cycles++;
        if (gate_lo && gate_hi) overlaps++;
        if (rst_n) begin
            if (lo_tick != (prev_lo && !gate_lo)) tick_errs++;
            prev_lo = gate_lo;
        end else begin
            prev_lo = 1'b0;
        end
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count consecutive samples where the chosen gate equals lvl.
    task automatic count_while(input int which, input logic lvl, output int n);
        n = 0;
        while (((which == 0) ? gate_lo : gate_hi) == lvl && n < 500) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic restart(input int hp, input int dt);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        half_period = CNT_W'(hp);
        dead_time   = CNT_W'(dt);
        enable = 1'b1;
    endtask

    initial begin
        int n, d, h, d2, l, rises, hi_hi;
        repeat (3) @(negedge clk);
        chk("R2 reset gate_lo", int'(gate_lo), 0);
        chk("R2 reset gate_hi", int'(gate_hi), 0);
        rst_n = 1'b1;
        boot_ok = 1'b1;

        // Vector table: R1 timing and R5 clamping.
        for (int i = 0; i < 6; i++) begin
            restart(VEC[i][0], VEC[i][1]);
            count_while(0, 1'b0, n);
            count_while(0, 1'b1, l);
            count_while(1, 1'b0, d);
            count_while(1, 1'b1, h);
            chk($sformatf("R1/R5 lo on-time vec %0d", i), l, VEC[i][2]);
            chk($sformatf("R1/R5 deadtime vec %0d", i), d, VEC[i][3]);
            chk($sformatf("R1/R5 hi on-time vec %0d", i), h, VEC[i][2]);
        end

        // R8: restart latency in the low-side half.
        restart(6, 2);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        count_while(0, 1'b0, n);
        chk("R8 lo first rise samples", n, 4);
        chk("R8 hi low before lo", int'(gate_hi), 0);

        // R2: disable while lo is high drops both on the next edge.
        enable = 1'b0;
        @(negedge clk);
        chk("R2 disable lo", int'(gate_lo), 0);
        chk("R2 disable hi", int'(gate_hi), 0);

        // R4: no high side without bootstrap; low side still switches.
        boot_ok = 1'b0;
        restart(5, 1);
        rises = 0;
        hi_hi = 0;
        for (int k = 0; k < 60; k++) begin
            logic was;
            was = gate_lo;
            @(negedge clk);
            if (!was && gate_lo) rises++;
            if (gate_hi) hi_hi++;
        end
        chk("R4 hi held low", hi_hi, 0);
        chk("R4 lo cycles while charging", int'(rises >= 5), 1);
        boot_ok = 1'b1;
        count_while(1, 1'b0, n);
        chk("R4 hi starts after boot_ok", int'(gate_hi), 1);

        // R6: mid-cycle update only takes effect at next low half.
        restart(10, 3);
        count_while(0, 1'b0, n);
        @(negedge clk);
        @(negedge clk);
        half_period = 16'd4;
        dead_time   = 16'd1;
        count_while(0, 1'b1, n);
        chk("R6 old lo remainder", n, 5);
        count_while(1, 1'b0, d);
        count_while(1, 1'b1, h);
        count_while(0, 1'b0, d2);
        count_while(0, 1'b1, l);
        chk("R6 old deadtime kept", d, 3);
        chk("R6 old hi on-time kept", h, 7);
        chk("R6 new low deadtime", d2, 1);
        chk("R6 new lo on-time", l, 3);

        // Reset mid-run clears outputs.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2 reset mid-run lo", int'(gate_lo), 0);
        chk("R2 reset mid-run hi", int'(gate_hi), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        chk("R3 overlap cycles", overlaps, 0);
        chk("R7 tick mismatches", tick_errs, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule